// File: doc/BRIEF.md
# Hot Subtrie Duplication Monitor

This block sits beside the entry stage of a multi-entrance lookup engine. It watches which subtrie each new lookup starts in. Every start arrives as one strobe with a subtrie ID. Over a repeating window of a fixed number of cycles, the block counts how often each subtrie is used and how many lookups there are in total. A subtrie whose share of the traffic is too large is marked as a candidate for an extra copy at a second entrance point.

When a window closes, the counts are frozen into a snapshot and the live counters start again from zero. A serial scanner then walks the subtrie IDs in ascending order, one ID per cycle. For each ID it compares the subtrie's share against a threshold given in parts per thousand. A candidate is issued as a request only if it is under two limits: a cap on copies per subtrie and a cap on the total across all subtries. Requests go out one at a time with a valid/ready handshake to the mapper.

The block keeps a per-subtrie table of copies already issued, and any entry can be read through a query port. It does not rebuild any trie. It only raises and records requests.

Top module: `dup_monitor`

## Requirements
- R1: After reset, `dup_valid` is 0, `total_dups` is 0, and `qry_copies` reads 0 for every ID.
- R2: A lookup is counted for subtrie `lk_id` only in a cycle where `lk_valid` is 1. Windows are `WINDOW` cycles long and the first starts at the first clock edge after reset release. The scan of a window evaluates ID k at the (k+1)-th edge after that window's last edge, so a request for ID k is visible after edge `WINDOW*(w+1)+k` (counting edges from 0).
- R3: A subtrie is hot only when count×1000 > `THRESH_PERMILLE`×total, with both counts taken over the same window. Equality is not hot, and a window with no lookups raises no request.
- R4: A subtrie is never given more than `PER_LIMIT` copies. Hot subtries that are at the limit are skipped.
- R5: No more than `GLOBAL_LIMIT` requests are ever issued. After the cap is reached, hot subtries raise nothing.
- R6: Requests from one scan appear in ascending ID order, at most one new request per cycle.
- R7: While `dup_valid` is 1 and `dup_ready` is 0, `dup_valid` stays 1, `dup_id` does not change, and the scan stalls.
- R8: Issuing a request adds one to that subtrie's copy count and one to `total_dups`. `qry_copies` returns the count for `qry_id`.
- R9: Counters clear at each window boundary, so traffic from earlier windows does not add to a later window's counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | One lookup starts this cycle |
| lk_id | input | ID_W | Subtrie in which the lookup starts |
| dup_valid | output | 1 | Duplication request pending |
| dup_id | output | ID_W | Subtrie to duplicate |
| dup_ready | input | 1 | Mapper accepts the pending request |
| qry_id | input | ID_W | Subtrie whose copy count is read |
| qry_copies | output | CPW | Copies issued so far for `qry_id` |
| total_dups | output | GW | Requests issued since reset |

## Verification
The bench goes after the exact-ratio boundary. A design that used >= instead of > would issue a request for a subtrie whose share equals the threshold. It also covers the empty window, where a design that did not guard against a zero total could flag every ID. Two caps are pushed to their edges. In one window the global cap is reached exactly on the last eligible ID, so a wrong comparison shows up as one request too many or too few, or as a skipped ID. A subtrie at its own limit must be passed over without blocking the IDs after it. Back-pressure checks that a stalled request keeps its ID and that the next hot ID is not lost. A strobe-less ID input must leave the counts untouched.

// File: rtl/dupmon_pkg.sv
package dupmon_pkg;
  // ratio thresholds are expressed in parts per this scale
  localparam int RATIO_SCALE = 1000;
  localparam int SCALE_W     = 10;
endpackage

// File: rtl/dupmon_usage.sv
module dupmon_usage #(
  parameter int N      = 16,
  parameter int WINDOW = 1000,
  parameter int CNT_W  = 16,
  localparam int ID_W  = (N > 1) ? $clog2(N) : 1,
  localparam int TW    = (WINDOW > 1) ? $clog2(WINDOW) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [ID_W-1:0]  lk_id,
  input  logic [ID_W-1:0]  rd_idx,
  output logic [CNT_W-1:0] rd_cnt,
  output logic [CNT_W-1:0] snap_total,
  output logic             win_end
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [TW-1:0]    tick_q, tick_d;
  logic             last;
  logic             id_ok;
  logic [CNT_W-1:0] tot_q, tot_d, tot_inc, stot_q, stot_d;
  logic [CNT_W-1:0] snap_arr [N];

  assign last  = (tick_q == TW'(WINDOW - 1));
  assign id_ok = lk_valid && ({1'b0, lk_id} < (ID_W+1)'(N));

  // window timer
  always_comb begin
    tick_d = last ? '0 : tick_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= '0;
    else        tick_q <= tick_d;
  end

  // total lookups in the window, saturating
  always_comb begin
    tot_inc = (id_ok && tot_q != CMAX) ? tot_q + 1'b1 : tot_q;
    tot_d   = last ? '0 : tot_inc;
    stot_d  = last ? tot_inc : stot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tot_q  <= '0;
      stot_q <= '0;
    end else begin
      tot_q  <= tot_d;
      stot_q <= stot_d;
    end
  end

  // one live counter and one snapshot per subtrie
  for (genvar gi = 0; gi < N; gi++) begin : g_cnt
    logic             hit;
    logic [CNT_W-1:0] live_q, live_d, snap_q, snap_d, inc;

    assign hit = id_ok && (lk_id == ID_W'(gi));

    always_comb begin
      inc    = (hit && live_q != CMAX) ? live_q + 1'b1 : live_q;
      live_d = last ? '0 : inc;
      snap_d = last ? inc : snap_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live_q <= '0;
        snap_q <= '0;
      end else begin
        live_q <= live_d;
        snap_q <= snap_d;
      end
    end

    assign snap_arr[gi] = snap_q;
  end

  assign rd_cnt     = ({1'b0, rd_idx} < (ID_W+1)'(N)) ? snap_arr[rd_idx] : '0;
  assign snap_total = stot_q;
  assign win_end    = last;
endmodule

// File: rtl/dupmon_scan.sv
module dupmon_scan
  import dupmon_pkg::*;
#(
  parameter int N               = 16,
  parameter int CNT_W           = 16,
  parameter int THRESH_PERMILLE = 15,
  parameter int PER_LIMIT       = 2,
  parameter int GLOBAL_LIMIT    = 20,
  localparam int ID_W = (N > 1) ? $clog2(N) : 1,
  localparam int CPW  = $clog2(PER_LIMIT + 1),
  localparam int GW   = $clog2(GLOBAL_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_end,
  output logic [ID_W-1:0]  rd_idx,
  input  logic [CNT_W-1:0] rd_cnt,
  input  logic [CNT_W-1:0] snap_total,
  output logic             dup_valid,
  output logic [ID_W-1:0]  dup_id,
  input  logic             dup_ready,
  input  logic [ID_W-1:0]  qry_id,
  output logic [CPW-1:0]   qry_copies,
  output logic [GW-1:0]    total_dups
);
  localparam int MW = CNT_W + SCALE_W + 1;

  logic            run_q, run_d;
  logic [ID_W-1:0] idx_q, idx_d;
  logic            req_v_q, req_v_d;
  logic [ID_W-1:0] req_id_q, req_id_d;
  logic [GW-1:0]   glob_q, glob_d;
  logic [CPW-1:0]  copy_arr [N];
  logic [CPW-1:0]  cur_copies;
  logic [MW-1:0]   lhs, rhs;
  logic            slot_free, step, hot, fire;

  assign slot_free  = !req_v_q || dup_ready;
  assign step       = run_q && slot_free;
  assign lhs        = MW'(rd_cnt) * MW'(RATIO_SCALE);
  assign rhs        = MW'(THRESH_PERMILLE) * MW'(snap_total);
  assign hot        = (snap_total != '0) && (lhs > rhs);
  assign cur_copies = copy_arr[idx_q];
  assign fire       = step && hot && (cur_copies < CPW'(PER_LIMIT))
                      && (glob_q < GW'(GLOBAL_LIMIT));

  // scan sequencer and request slot
  always_comb begin
    run_d    = run_q;
    idx_d    = idx_q;
    req_v_d  = req_v_q;
    req_id_d = req_id_q;
    glob_d   = glob_q;
    if (step) begin
      if (idx_q == ID_W'(N - 1)) run_d = 1'b0;
      else                       idx_d = idx_q + 1'b1;
    end
    if (win_end) begin
      run_d = 1'b1;
      idx_d = '0;
    end
    if (fire) begin
      req_v_d  = 1'b1;
      req_id_d = idx_q;
      glob_d   = glob_q + 1'b1;
    end else if (dup_ready) begin
      req_v_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      idx_q    <= '0;
      req_v_q  <= 1'b0;
      req_id_q <= '0;
      glob_q   <= '0;
    end else begin
      run_q    <= run_d;
      idx_q    <= idx_d;
      req_v_q  <= req_v_d;
      req_id_q <= req_id_d;
      glob_q   <= glob_d;
    end
  end

  // copy table
  for (genvar gi = 0; gi < N; gi++) begin : g_copy
    logic [CPW-1:0] cp_q, cp_d;
    logic           cp_en;

    assign cp_en = fire && (idx_q == ID_W'(gi));

    always_comb begin
      cp_d = cp_en ? cp_q + 1'b1 : cp_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cp_q <= '0;
      else        cp_q <= cp_d;
    end

    assign copy_arr[gi] = cp_q;
  end

  assign rd_idx     = idx_q;
  assign dup_valid  = req_v_q;
  assign dup_id     = req_id_q;
  assign total_dups = glob_q;
  assign qry_copies = ({1'b0, qry_id} < (ID_W+1)'(N)) ? copy_arr[qry_id] : '0;
endmodule

// File: rtl/dup_monitor.sv
module dup_monitor #(
  parameter int NUM_SUBTRIES    = 16,
  parameter int WINDOW          = 1000,
  parameter int CNT_W           = 16,
  parameter int THRESH_PERMILLE = 15,
  parameter int PER_LIMIT       = 2,
  parameter int GLOBAL_LIMIT    = 20,
  localparam int ID_W = (NUM_SUBTRIES > 1) ? $clog2(NUM_SUBTRIES) : 1,
  localparam int CPW  = $clog2(PER_LIMIT + 1),
  localparam int GW   = $clog2(GLOBAL_LIMIT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [ID_W-1:0] lk_id,
  output logic            dup_valid,
  output logic [ID_W-1:0] dup_id,
  input  logic            dup_ready,
  input  logic [ID_W-1:0] qry_id,
  output logic [CPW-1:0]  qry_copies,
  output logic [GW-1:0]   total_dups
);
  logic [ID_W-1:0]  rd_idx;
  logic [CNT_W-1:0] rd_cnt;
  logic [CNT_W-1:0] snap_total;
  logic             win_end;

  dupmon_usage #(
    .N(NUM_SUBTRIES), .WINDOW(WINDOW), .CNT_W(CNT_W)
  ) u_usage (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_id(lk_id),
    .rd_idx(rd_idx), .rd_cnt(rd_cnt), .snap_total(snap_total),
    .win_end(win_end)
  );

  dupmon_scan #(
    .N(NUM_SUBTRIES), .CNT_W(CNT_W), .THRESH_PERMILLE(THRESH_PERMILLE),
    .PER_LIMIT(PER_LIMIT), .GLOBAL_LIMIT(GLOBAL_LIMIT)
  ) u_scan (
    .clk(clk), .rst_n(rst_n), .win_end(win_end), .rd_idx(rd_idx),
    .rd_cnt(rd_cnt), .snap_total(snap_total), .dup_valid(dup_valid),
    .dup_id(dup_id), .dup_ready(dup_ready), .qry_id(qry_id),
    .qry_copies(qry_copies), .total_dups(total_dups)
  );
endmodule

// File: rtl/dup_monitor_chk.sv
module dup_monitor_chk #(
  parameter int ID_W         = 4,
  parameter int CPW          = 2,
  parameter int GW           = 5,
  parameter int PER_LIMIT    = 2,
  parameter int GLOBAL_LIMIT = 20
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dup_valid,
  input logic            dup_ready,
  input logic [ID_W-1:0] dup_id,
  input logic [CPW-1:0]  qry_copies,
  input logic [GW-1:0]   total_dups
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dup_valid && !dup_ready) |=> (dup_valid && $stable(dup_id))); // R7

  AST_GLOBAL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    total_dups <= GW'(GLOBAL_LIMIT)); // R5

  AST_COPY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    qry_copies <= CPW'(PER_LIMIT)); // R4

  AST_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (total_dups == $past(total_dups)) || (total_dups == $past(total_dups) + 1'b1)); // R6

  AST_NEW_REQ_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
    (dup_valid && !($past(dup_valid) && !$past(dup_ready)))
      |-> (total_dups == $past(total_dups) + 1'b1)); // R8

  AST_COUNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (total_dups != $past(total_dups)) |-> dup_valid); // R8
endmodule

bind dup_monitor dup_monitor_chk #(
  .ID_W(ID_W), .CPW(CPW), .GW(GW),
  .PER_LIMIT(PER_LIMIT), .GLOBAL_LIMIT(GLOBAL_LIMIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dup_valid(dup_valid), .dup_ready(dup_ready),
  .dup_id(dup_id), .qry_copies(qry_copies), .total_dups(total_dups)
);

// File: tb/tb_dup_monitor.sv
module tb_dup_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 1000;
  localparam int NV         = 7;

  typedef struct packed {
    logic [3:0]  ia; logic [9:0] na;
    logic [3:0]  ib; logic [9:0] nb;
    logic [3:0]  ic; logic [9:0] nc;
    logic [7:0]  nall;
    logic [15:0] mask;
  } vec_t;

  // per window: three (id,count) bursts, then nall lookups on every ID; expected request mask
  localparam vec_t VECS [NV] = '{
    '{4'd2, 10'd100, 4'd5, 10'd1,   4'd9,  10'd0,  8'd0,  16'h0004}, // R3 basic
    '{4'd2, 10'd50,  4'd5, 10'd2,   4'd14, 10'd48, 8'd0,  16'h4024}, // R6 several
    '{4'd2, 10'd60,  4'd5, 10'd1,   4'd14, 10'd60, 8'd0,  16'h4000}, // R4 id2 at cap, R9
    '{4'd3, 10'd3,   4'd4, 10'd197, 4'd0,  10'd0,  8'd0,  16'h0010}, // R3 equality
    '{4'd0, 10'd0,   4'd0, 10'd0,   4'd0,  10'd0,  8'd0,  16'h0000}, // R3 empty
    '{4'd0, 10'd0,   4'd0, 10'd0,   4'd0,  10'd0,  8'd50, 16'hBFFB}, // R5 reaches cap
    '{4'd0, 10'd0,   4'd0, 10'd0,   4'd0,  10'd0,  8'd50, 16'h0000}  // R5 cap held
  };

  logic       clk, rst_n, lk_valid, dup_ready, dup_valid;
  logic [3:0] lk_id, dup_id, qry_id;
  logic [1:0] qry_copies;
  logic [4:0] total_dups;

  int checks, errors, cyc, nlog, last_id;
  bit order_bad, done;
  int logq [32];

  dup_monitor dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_id(lk_id),
    .dup_valid(dup_valid), .dup_id(dup_id), .dup_ready(dup_ready),
    .qry_id(qry_id), .qry_copies(qry_copies), .total_dups(total_dups)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // record accepted requests, sampled after the driving negedge settles
  always @(negedge clk) begin
    #1;
    if (rst_n && dup_valid && dup_ready) begin
      if (nlog > 0 && int'(dup_id) <= last_id) order_bad = 1'b1;
      last_id = int'(dup_id);
      if (nlog < 32) logq[nlog] = int'(dup_id);
      nlog++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cyc++;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) tick();
  endtask

  task automatic clear_log();
    nlog = 0; last_id = -1; order_bad = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; lk_valid = 1'b0; lk_id = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    clear_log();
  endtask

  task automatic burst(input int id, input int n);
    for (int i = 0; i < n; i++) begin
      lk_valid = 1'b1; lk_id = 4'(id);
      tick();
    end
    lk_valid = 1'b0;
  endtask

  task automatic query(input int id, input int exp, input string req);
    qry_id = 4'(id);
    #1;
    chk(int'(qry_copies) == exp, req, int'(qry_copies), exp);
  endtask

  initial begin
    done = 1'b0; checks = 0; errors = 0; cyc = 0;
    rst_n = 1'b0; lk_valid = 1'b0; lk_id = '0; dup_ready = 1'b1; qry_id = '0;
    clear_log();
    do_reset();
    #1;
    // R1 reset state
    chk(dup_valid == 1'b0, "R1 valid", int'(dup_valid), 0);
    chk(total_dups == 0, "R1 total", int'(total_dups), 0);
    query(2, 0, "R1 copies");

    for (int v = 0; v < NV; v++) begin
      int base;
      logic [15:0] got;
      base = v * WIN;
      wait_until(base + 30);
      burst(int'(VECS[v].ia), int'(VECS[v].na));
      burst(int'(VECS[v].ib), int'(VECS[v].nb));
      burst(int'(VECS[v].ic), int'(VECS[v].nc));
      for (int r = 0; r < int'(VECS[v].nall); r++)
        for (int k = 0; k < 16; k++) burst(k, 1);
      clear_log();
      wait_until(base + WIN + 30);
      got = '0;
      for (int j = 0; j < nlog && j < 32; j++) got[logq[j]] = 1'b1;
      chk(got == VECS[v].mask, "R3/R4/R5 request set", int'(got), int'(VECS[v].mask));
      chk(nlog == $countones(VECS[v].mask), "R6 request count", nlog, $countones(VECS[v].mask));
      chk(!order_bad, "R6 ascending", int'(order_bad), 0);
    end

    // R5 and R8: cap reached, table contents
    chk(total_dups == 20, "R5 total at cap", int'(total_dups), 20);
    query(2, 2, "R8 copies id2");
    query(14, 2, "R8 copies id14");
    query(0, 1, "R8 copies id0");
    query(4, 2, "R8 copies id4");

    // R1: second reset clears the table
    do_reset();
    #1;
    query(2, 0, "R1 copies after reset");
    chk(total_dups == 0, "R1 total after reset", int'(total_dups), 0);

    // R2/R7: strobe-less ID ignored, back-pressure, request timing
    dup_ready = 1'b0;
    wait_until(30);
    for (int i = 0; i < 100; i++) begin
      lk_valid = 1'b0; lk_id = 4'd3;
      tick();
    end
    burst(7, 100);
    burst(9, 100);
    wait_until(WIN + 7);
    chk(dup_valid == 1'b0, "R2 not before edge", int'(dup_valid), 0);
    tick();
    chk(dup_valid == 1'b1, "R2 visible at edge", int'(dup_valid), 1);
    chk(dup_id == 4'd7, "R2 first id", int'(dup_id), 7);
    wait_until(WIN + 20);
    chk(dup_valid == 1'b1 && dup_id == 4'd7, "R7 held", int'(dup_id), 7);
    clear_log();
    dup_ready = 1'b1;
    wait_until(WIN + 40);
    chk(nlog == 2, "R7 count after release", nlog, 2);
    chk(nlog >= 2 && logq[0] == 7 && logq[1] == 9, "R7 order after release", logq[1], 9);
    query(3, 0, "R2 ignored id3");
    query(7, 1, "R8 copies id7");
    chk(total_dups == 2, "R8 total", int'(total_dups), 2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule